// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block is a register-mapped target that sits beside a shared second-level cache controller and performs cache maintenance over a byte range chosen by software. Software programs a 64-bit base address as two 32-bit halves and a byte length, then writes a command word. That final write starts a walk over every cache line the range overlaps. For each line, one request goes out on a line port: an invalidate or a write-back.

Line requests go out one at a time, in ascending address order. Each request is held until the cache side acknowledges it. The response to the launching command write is withheld until the last line has been acknowledged. Software therefore sees the whole maintenance operation complete when that single write completes. There is no lock: while a command is running, the register port refuses new accesses, so only one command is ever in flight.

Top module: `cmo_range_engine`

## Requirements
- R1: After reset every register reads zero (the command register reads NOP, encoded 0), `reg_ready` is high and `line_req_valid` is low.
- R2: A write to index 0 (address low half), 1 (address high half) or 2 (length in bytes) that uses byte enables 4'hF loads that register. A read of index 0 to 3 returns the current value. Each such access is answered by `rsp_valid` one cycle after it is accepted, with `rsp_err` low.
- R3: A write of INVAL (1) or SYNC (2) to index 3 launches a walk over N = ceil((base mod 64 + length) / 64) lines. The first line address is the base rounded down to a multiple of 64, and each following line is 64 bytes higher.
- R4: Line requests are issued one at a time in ascending order. `line_req_op` is 0 (invalidate) for INVAL and 1 (write-back) for SYNC. A request and its address stay stable until `line_ack` is seen with it.
- R5: The response to a launching command write is asserted exactly one cycle after the cycle in which the final line is acknowledged, and never earlier.
- R6: A command write of NOP (0), or of INVAL or SYNC with length 0, issues no line request and is answered one cycle after acceptance.
- R7: While a walk is in progress `reg_ready` is low and no register access is accepted. `line_ack` without a pending request has no effect.
- R8: A read of index 3 returns the last command value accepted.
- R9: An access to index 4 or above, a write whose byte enables are not 4'hF, or a command write with a value above 2 gets `rsp_err` high. No register changes and no line request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted when high together with reg_req |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Register index |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Error flag of the response |
| rsp_rdata | output | 32 | Read data of the response |
| line_req_valid | output | 1 | Line maintenance request pending |
| line_req_op | output | 1 | 0 = invalidate, 1 = write-back |
| line_req_addr | output | 64 | Line-aligned address of the request |
| line_ack | input | 1 | Cache side has completed the pending line |

## Verification
The bench builds the block with its default parameters: 32-bit register words, a 64-bit address, 64-byte lines and a 3-bit register index. The 3-bit index puts undefined indexes 4 to 7 within reach of the error cases. A 32-bit length lets a range start one byte before a line boundary and straddle into the next line, so the range-to-line arithmetic is exercised at its edges. A base near the top of the 64-bit space is used to check that the high address half travels through the walk intact.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_INVAL = 2'd1,
    CMD_SYNC  = 2'd2
  } cmd_e;

  localparam int unsigned IDX_ADDR_LO = 0;
  localparam int unsigned IDX_ADDR_HI = 1;
  localparam int unsigned IDX_LENGTH  = 2;
  localparam int unsigned IDX_COMMAND = 3;

  // Number of lines touched by [base, base+len-1]; zero when len is zero.
  function automatic logic [63:0] lines_touched(input logic [63:0] base,
                                                input logic [31:0] len,
                                                input int unsigned line_sh);
    logic [63:0] mask;
    logic [63:0] span;
    mask = (64'd1 << line_sh) - 64'd1;
    span = (base & mask) + {32'd0, len};
    if (len == 32'd0) return 64'd0;
    return (span + mask) >> line_sh;
  endfunction

  // Base rounded down to a line boundary.
  function automatic logic [63:0] line_floor(input logic [63:0] base,
                                             input int unsigned line_sh);
    return base & ~((64'd1 << line_sh) - 64'd1);
  endfunction

endpackage

// File: rtl/cmo_reg_bank.sv
module cmo_reg_bank
  import cmo_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [BE_W-1:0]   acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [DATA_W-1:0] len_q,
  output cmd_e              cmd_q,
  output logic [DATA_W-1:0] rdata_nx,
  output logic              err_nx,
  output logic              cmd_wr_evt
);

  logic idx_bad;
  logic be_bad;
  logic cmd_bad;
  logic wr_ok;

  assign idx_bad = acc_idx > IDX_W'(IDX_COMMAND);
  assign be_bad  = acc_we && (acc_be != {BE_W{1'b1}});
  assign cmd_bad = acc_we && (acc_idx == IDX_W'(IDX_COMMAND)) &&
                   (acc_wdata > DATA_W'(CMD_SYNC));
  assign err_nx  = idx_bad || be_bad || cmd_bad;
  assign wr_ok   = acc_fire && acc_we && !err_nx;
  assign cmd_wr_evt = wr_ok && (acc_idx == IDX_W'(IDX_COMMAND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      cmd_q  <= CMD_NOP;
    end else if (wr_ok) begin
      case (acc_idx)
        IDX_W'(IDX_ADDR_LO): base_q[DATA_W-1:0]      <= acc_wdata;
        IDX_W'(IDX_ADDR_HI): base_q[ADDR_W-1:DATA_W] <= acc_wdata;
        IDX_W'(IDX_LENGTH):  len_q                   <= acc_wdata;
        default:             cmd_q <= cmd_e'(acc_wdata[1:0]);
      endcase
    end
  end

  always_comb begin
    rdata_nx = '0;
    case (acc_idx)
      IDX_W'(IDX_ADDR_LO): rdata_nx = base_q[DATA_W-1:0];
      IDX_W'(IDX_ADDR_HI): rdata_nx = base_q[ADDR_W-1:DATA_W];
      IDX_W'(IDX_LENGTH):  rdata_nx = len_q;
      IDX_W'(IDX_COMMAND): rdata_nx = DATA_W'(cmd_q);
      default:             rdata_nx = '0;
    endcase
  end

endmodule

// File: rtl/cmo_line_walker.sv
module cmo_line_walker #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned CNT_W      = 33,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [CNT_W-1:0]  line_cnt,
  input  logic              op_wb,
  input  logic              ack,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_op,
  output logic              active,
  output logic              last_line,
  output logic              done_evt
);

  logic [CNT_W-1:0] remain_q;

  assign req_valid = active;
  assign last_line = active && (remain_q == CNT_W'(1));
  assign done_evt  = last_line && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      remain_q <= '0;
      req_addr <= '0;
      req_op   <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      remain_q <= line_cnt;
      req_addr <= first_addr;
      req_op   <= op_wb;
    end else if (active && ack) begin
      remain_q <= remain_q - CNT_W'(1);
      req_addr <= req_addr + ADDR_W'(LINE_BYTES);
      if (remain_q == CNT_W'(1)) active <= 1'b0;
    end
  end

endmodule

// File: rtl/cmo_range_engine.sv
module cmo_range_engine
  import cmo_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned BE_W    = DATA_W / 8,
  localparam int unsigned ADDR_W  = 2 * DATA_W,
  localparam int unsigned CNT_W   = DATA_W + 1,
  localparam int unsigned LINE_SH = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  output logic              reg_ready,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              line_req_valid,
  output logic              line_req_op,
  output logic [ADDR_W-1:0] line_req_addr,
  input  logic              line_ack
);

  logic              busy_q;
  logic              acc_fire;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] len_q;
  cmd_e              cmd_q;
  logic [DATA_W-1:0] rdata_nx;
  logic              err_nx;
  logic              cmd_wr_evt;
  cmd_e              cmd_new;
  logic [63:0]       cnt_full;
  logic [CNT_W-1:0]  cnt_now;
  logic              walk_start;
  logic              walk_active;
  logic              walk_last;
  logic              walk_done;

  assign reg_ready = !busy_q;
  assign acc_fire  = reg_req && reg_ready;

  cmo_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .acc_fire(acc_fire), .acc_we(reg_we), .acc_idx(reg_idx),
    .acc_be(reg_be), .acc_wdata(reg_wdata),
    .base_q(base_q), .len_q(len_q), .cmd_q(cmd_q),
    .rdata_nx(rdata_nx), .err_nx(err_nx), .cmd_wr_evt(cmd_wr_evt)
  );

  assign cmd_new    = cmd_e'(reg_wdata[1:0]);
  assign cnt_full   = lines_touched(64'(base_q), 32'(len_q), LINE_SH);
  assign cnt_now    = cnt_full[CNT_W-1:0];
  assign walk_start = cmd_wr_evt && (cmd_new != CMD_NOP) && (cnt_now != '0);

  cmo_line_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)) walk_i (
    .clk(clk), .rst_n(rst_n),
    .start(walk_start),
    .first_addr(ADDR_W'(line_floor(64'(base_q), LINE_SH))),
    .line_cnt(cnt_now),
    .op_wb(cmd_new == CMD_SYNC),
    .ack(line_ack),
    .req_valid(line_req_valid), .req_addr(line_req_addr), .req_op(line_req_op),
    .active(walk_active), .last_line(walk_last), .done_evt(walk_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (walk_start)     busy_q <= 1'b1;
      else if (walk_done) busy_q <= 1'b0;
      rsp_valid <= (acc_fire && !walk_start) || walk_done;
      rsp_err   <= acc_fire && err_nx;
      rsp_rdata <= (acc_fire && !reg_we && !err_nx) ? rdata_nx : '0;
    end
  end

endmodule

// File: rtl/cmo_range_engine_chk.sv
module cmo_range_engine_chk #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              line_req_valid,
  input logic              line_req_op,
  input logic [ADDR_W-1:0] line_req_addr,
  input logic              line_ack,
  input logic              walk_active,
  input logic              walk_last,
  input logic              walk_done,
  input logic [ADDR_W-1:0] base_q
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    line_req_valid && !line_ack |=> line_req_valid && $stable(line_req_addr) && $stable(line_req_op)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    line_req_valid && line_ack && !walk_last |=>
      line_req_addr == $past(line_req_addr) + ADDR_W'(LINE_BYTES)); // R3

  AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid && !rsp_err); // R5

  AST_NO_EARLY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active && !walk_done |=> !rsp_valid); // R5

  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    walk_active |-> !reg_ready); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready |-> !line_req_valid); // R7

  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> $stable(base_q) && !line_req_valid); // R9

endmodule

bind cmo_range_engine cmo_range_engine_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_ready(reg_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .line_req_valid(line_req_valid), .line_req_op(line_req_op),
  .line_req_addr(line_req_addr), .line_ack(line_ack),
  .walk_active(walk_active), .walk_last(walk_last), .walk_done(walk_done),
  .base_q(base_q)
);

// File: tb/cmo_range_engine_tb_top.sv
module cmo_range_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0;
  logic        reg_ready;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        line_req_valid;
  logic        line_req_op;
  logic [63:0] line_req_addr;
  logic        line_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic        got_err;
  logic [31:0] got_data;

  always #2.5 clk = ~clk;

  cmo_range_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .line_req_valid(line_req_valid), .line_req_op(line_req_op),
    .line_req_addr(line_req_addr), .line_ack(line_ack)
  );

  typedef struct packed {
    logic [63:0] base;
    logic [31:0] len;
    logic [1:0]  cmd;
    logic [7:0]  n_lines;
    logic [63:0] first;
    logic [3:0]  gap;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_1000, 32'd64,  2'd1, 8'd1, 64'h0000_0000_0000_1000, 4'd0},
    '{64'h0000_0000_0000_1010, 32'd64,  2'd2, 8'd2, 64'h0000_0000_0000_1000, 4'd2},
    '{64'h0000_0001_0000_003F, 32'd2,   2'd1, 8'd2, 64'h0000_0001_0000_0000, 4'd1},
    '{64'h0000_0000_0000_2000, 32'd1,   2'd2, 8'd1, 64'h0000_0000_0000_2000, 4'd3},
    '{64'hFFFF_FFFF_0000_0040, 32'd256, 2'd2, 8'd4, 64'hFFFF_FFFF_0000_0040, 4'd1},
    '{64'h0000_0000_0000_3004, 32'd0,   2'd1, 8'd0, 64'h0,                   4'd0},
    '{64'h0000_0000_0000_5000, 32'd200, 2'd0, 8'd0, 64'h0,                   4'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one access, wait for acceptance, capture the response one cycle later.
  task automatic access(input bit we, input logic [2:0] idx, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    reg_req = 1'b1; reg_we = we; reg_idx = idx; reg_be = be; reg_wdata = wd;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_req = 1'b0;
    check(rsp_valid == 1'b1, "R2 response one cycle after accept", 64'(rsp_valid), 64'd1);
    got_err = rsp_err;
    got_data = rsp_rdata;
  endtask

  task automatic program_regs(input logic [63:0] base, input logic [31:0] len);
    access(1'b1, 3'd0, 4'hF, base[31:0]);
    access(1'b1, 3'd1, 4'hF, base[63:32]);
    access(1'b1, 3'd2, 4'hF, len);
  endtask

  // Command write plus servicing of every expected line request.
  task automatic launch(input logic [1:0] cmd, input int n_exp, input logic [63:0] first,
                        input int gap, input bit probe);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_idx = 3'd3; reg_be = 4'hF; reg_wdata = {30'd0, cmd};
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_req = 1'b0;
    if (probe) begin reg_req = 1'b1; reg_we = 1'b0; reg_idx = 3'd0; end
    if (n_exp == 0) begin
      check(rsp_valid && !rsp_err, "R6 immediate response", 64'(rsp_valid), 64'd1);
      check(!line_req_valid, "R6 no line request", 64'(line_req_valid), 64'd0);
    end
    for (int i = 0; i < n_exp; i++) begin
      for (int g = 0; g <= gap; g++) begin
        check(line_req_valid, "R4 request pending", 64'(line_req_valid), 64'd1);
        check(line_req_addr == first + 64'(64 * i), "R3 line address", line_req_addr, first + 64'(64 * i));
        check(line_req_op == (cmd == 2'd2), "R4 line op", 64'(line_req_op), 64'(cmd == 2'd2));
        check(!rsp_valid, "R5 no early response", 64'(rsp_valid), 64'd0);
        if (probe) check(!reg_ready, "R7 stalled while busy", 64'(reg_ready), 64'd0);
        if (g < gap) @(negedge clk);
      end
      line_ack = 1'b1;
      @(negedge clk);
      line_ack = 1'b0;
    end
    if (n_exp > 0) begin
      check(rsp_valid && !rsp_err, "R5 response after last ack", 64'(rsp_valid), 64'd1);
      check(!line_req_valid, "R3 walk covers exact count", 64'(line_req_valid), 64'd0);
      if (probe) check(reg_ready, "R7 ready after completion", 64'(reg_ready), 64'd1);
    end
    reg_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_ready, "R1 ready after reset", 64'(reg_ready), 64'd1);
    check(!line_req_valid, "R1 no request after reset", 64'(line_req_valid), 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 3'(k), 4'h0, 32'd0);
      check(!got_err && got_data == 32'd0, "R1 register zero after reset", 64'(got_data), 64'd0);
    end

    // Vector table
    for (int v = 0; v < NV; v++) begin
      program_regs(VECS[v].base, VECS[v].len);
      access(1'b0, 3'd2, 4'h0, 32'd0);
      check(!got_err && got_data == VECS[v].len, "R2 length readback", 64'(got_data), 64'(VECS[v].len));
      access(1'b0, 3'd1, 4'h0, 32'd0);
      check(got_data == VECS[v].base[63:32], "R2 high half readback", 64'(got_data), 64'(VECS[v].base[63:32]));
      launch(VECS[v].cmd, int'(VECS[v].n_lines), VECS[v].first, int'(VECS[v].gap), 1'b0);
      access(1'b0, 3'd3, 4'h0, 32'd0);
      check(got_data == 32'(VECS[v].cmd), "R8 command readback", 64'(got_data), 64'(VECS[v].cmd));
    end

    // R7 stall of a register access during a three-line walk
    program_regs(64'h0000_0000_0000_7020, 32'd130);
    launch(2'd1, 3, 64'h0000_0000_0000_7000, 1, 1'b1);

    // R7 stray acknowledge while idle
    @(negedge clk);
    line_ack = 1'b1;
    @(negedge clk);
    line_ack = 1'b0;
    check(!line_req_valid && !rsp_valid, "R7 stray ack ignored", 64'(line_req_valid), 64'd0);
    check(reg_ready, "R7 still ready after stray ack", 64'(reg_ready), 64'd1);

    // R9 undefined index
    access(1'b0, 3'd5, 4'h0, 32'd0);
    check(got_err, "R9 undefined index read", 64'(got_err), 64'd1);
    access(1'b1, 3'd4, 4'hF, 32'h1234);
    check(got_err, "R9 undefined index write", 64'(got_err), 64'd1);
    // R9 partial write leaves register unchanged
    access(1'b1, 3'd0, 4'h3, 32'hDEAD_BEEF);
    check(got_err, "R9 partial write error", 64'(got_err), 64'd1);
    access(1'b0, 3'd0, 4'h0, 32'd0);
    check(got_data == 32'h0000_7020, "R9 partial write no effect", 64'(got_data), 64'h7020);
    // R9 bad command value: no launch, command unchanged
    access(1'b1, 3'd3, 4'hF, 32'd3);
    check(got_err && !line_req_valid, "R9 bad command rejected", 64'(got_err), 64'd1);
    access(1'b0, 3'd3, 4'h0, 32'd0);
    check(got_data == 32'd1, "R9 command unchanged", 64'(got_data), 64'd1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule